// File: doc/BRIEF.md
# CAN Receive Acceptance Rule Filter

This block decides, for one CAN channel, whether a received frame is kept and where it goes. Software loads a table of up to `NUM_RULES` receive rules and a count of how many of them are active. Each rule holds a reference identifier, reference IDE and RTR values, a compare mask for each of the three, a minimum DLC, a label, and a destination: a receive-buffer index with an enable, plus a bit mask that selects FIFOs.

When the protocol engine presents a frame header (identifier, IDE, RTR, DLC) on a valid/ready handshake, the block walks the active rules from rule 0 upward, one rule per clock. The first rule whose compared identifier, IDE and RTR bits all agree with the frame stops the walk. That rule's DLC threshold then decides acceptance. A one-cycle result strobe reports accept or discard, the index of the rule that hit, and that rule's label, DLC value and destination. Storing the message, the FIFOs themselves and the bit-level protocol sit outside this block.

Top module: `can_rx_rule_filter`

## Requirements
- R1: `frmReady` is high exactly when no walk is in progress. A frame is taken on a clock edge where `frmValid` and `frmReady` are both high. `frmReady` is low from the cycle after that edge until the result cycle, and it is high again in the result cycle.
- R2: Rules are tried in increasing index order. When several active rules agree with the frame, the lowest index is reported on `resRuleIdx`.
- R3: A mask bit of 1 means the bit is compared and a mask bit of 0 means it is treated as matching. Identifier mask bit i guards identifier bit i. The IDE mask guards IDE and the RTR mask guards RTR.
- R4: For a frame with IDE = 0, only identifier bits 10:0 are compared, whatever the rule's upper identifier or mask bits hold. For a frame with IDE = 1, all 29 bits are compared.
- R5: Only rules 0 to count-1 are tried, where count is the last value written on `cntWrData`. A written value above `NUM_RULES` is held as `NUM_RULES`. With a count of 0, no frame is ever accepted.
- R6: The first identifier hit ends the walk. If that rule's DLC value is non-zero and the frame's DLC is smaller, the frame is discarded and no later rule is tried. A rule DLC value of 0 accepts any frame DLC.
- R7: Counting from the edge that takes the frame, the walk takes one cycle per rule. A stop at rule k (an accept or a DLC discard) puts `resValid` high in cycle k+1. A walk over n ≥ 1 active rules with no hit puts it high in cycle n, and a count of 0 puts it high in cycle 1.
- R8: In the result cycle, an accept drives `resMatch` = 1 together with the hit rule's index, label, DLC value, buffer enable, buffer index and FIFO mask. A discard drives `resMatch` = 0 and all of those fields to 0.
- R9: Rule writes (`ruleWrEn`) and count writes (`cntWrEn`) on an edge where `frmReady` is low are dropped and are not applied later.
- R10: `resValid` is high for exactly one cycle per frame taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset; clears the table and sets the count to 0 |
| ruleWrEn | input | 1 | Writes one whole rule |
| ruleWrIdx | input | IDX_W | Index of the rule being written |
| ruleWrId | input | ID_W | Reference identifier |
| ruleWrIde | input | 1 | Reference IDE value |
| ruleWrRtr | input | 1 | Reference RTR value |
| ruleWrIdMask | input | ID_W | Identifier compare mask (1 = compare) |
| ruleWrIdeMask | input | 1 | IDE compare enable |
| ruleWrRtrMask | input | 1 | RTR compare enable |
| ruleWrDlc | input | DLC_W | Minimum DLC (0 = no DLC check) |
| ruleWrLabel | input | LABEL_W | Label attached on accept |
| ruleWrBufEn | input | 1 | Route to a receive buffer |
| ruleWrBufIdx | input | BUF_W | Receive buffer index |
| ruleWrFifoSel | input | FIFO_W | FIFO select mask |
| cntWrEn | input | 1 | Writes the active rule count |
| cntWrData | input | CNT_W | New active rule count (clamped to NUM_RULES) |
| frmValid | input | 1 | Frame header offered |
| frmReady | output | 1 | Block can take a frame |
| frmId | input | ID_W | Frame identifier |
| frmIde | input | 1 | Frame IDE bit |
| frmRtr | input | 1 | Frame RTR bit |
| frmDlc | input | DLC_W | Frame DLC |
| resValid | output | 1 | One-cycle result strobe |
| resMatch | output | 1 | Frame accepted |
| resRuleIdx | output | IDX_W | Index of the accepting rule |
| resLabel | output | LABEL_W | Label of the accepting rule |
| resDlc | output | DLC_W | DLC value of the accepting rule |
| resBufEn | output | 1 | Buffer routing enable of the accepting rule |
| resBufIdx | output | BUF_W | Buffer index of the accepting rule |
| resFifoSel | output | FIFO_W | FIFO mask of the accepting rule |

## Verification
A wrong walk index or a stop decision that fires one rule late shows at the ports in the same result. The reported rule number is then off, and so is the strobe's cycle counted from acceptance, since the strobe position encodes how many rules were tried. A corrupted count or a table write that slips through during a walk shows as a discard that comes at the wrong cycle, or as a later frame hitting a rule that software never meant to load. The sweeps therefore check the index, the payload and the exact strobe cycle for every frame. A second frame after each write-during-walk probe exposes a dropped write that was applied late.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFrame;
    logic stepIdx;
    logic capture;
    logic tableWrOk;
  } rxf_ctl_t;

  // status from datapath to control
  typedef struct packed {
    logic inRange;
    logic idHit;
    logic dlcOk;
    logic lastRule;
  } rxf_sts_t;

endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frmValid,
  input  rxf_sts_t sts,
  output rxf_ctl_t ctl,
  output logic     frmReady,
  output logic     resValid
);

  scan_state_e state, stateNext;
  logic        stopNow;

  // walk ends on an out-of-range index, an identifier hit or the last rule
  assign stopNow = !sts.inRange || sts.idHit || sts.lastRule;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    ctl.tableWrOk = (state == ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (frmValid) begin
          ctl.loadFrame = 1'b1;
          stateNext     = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (stopNow) begin
          ctl.capture = 1'b1;
          stateNext   = ST_IDLE;
        end else begin
          ctl.stepIdx = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      resValid <= 1'b0;
    end else begin
      state    <= stateNext;
      resValid <= ctl.capture;
    end
  end

  assign frmReady = (state == ST_IDLE);

endmodule

// File: rtl/rxf_dp.sv
module rxf_dp
  import rxf_pkg::*;
#(
  parameter int NUM_RULES = 16,
  parameter int ID_W      = 29,
  parameter int STD_ID_W  = 11,
  parameter int DLC_W     = 4,
  parameter int LABEL_W   = 12,
  parameter int BUF_W     = 4,
  parameter int FIFO_W    = 3,
  localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1,
  localparam int CNT_W    = $clog2(NUM_RULES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  rxf_ctl_t           ctl,
  output rxf_sts_t           sts,
  input  logic               ruleWrEn,
  input  logic [IDX_W-1:0]   ruleWrIdx,
  input  logic [ID_W-1:0]    ruleWrId,
  input  logic               ruleWrIde,
  input  logic               ruleWrRtr,
  input  logic [ID_W-1:0]    ruleWrIdMask,
  input  logic               ruleWrIdeMask,
  input  logic               ruleWrRtrMask,
  input  logic [DLC_W-1:0]   ruleWrDlc,
  input  logic [LABEL_W-1:0] ruleWrLabel,
  input  logic               ruleWrBufEn,
  input  logic [BUF_W-1:0]   ruleWrBufIdx,
  input  logic [FIFO_W-1:0]  ruleWrFifoSel,
  input  logic               cntWrEn,
  input  logic [CNT_W-1:0]   cntWrData,
  input  logic [ID_W-1:0]    frmId,
  input  logic               frmIde,
  input  logic               frmRtr,
  input  logic [DLC_W-1:0]   frmDlc,
  output logic [CNT_W-1:0]   ruleCount,
  output logic               resMatch,
  output logic [IDX_W-1:0]   resRuleIdx,
  output logic [LABEL_W-1:0] resLabel,
  output logic [DLC_W-1:0]   resDlc,
  output logic               resBufEn,
  output logic [BUF_W-1:0]   resBufIdx,
  output logic [FIFO_W-1:0]  resFifoSel
);

  localparam logic [ID_W-1:0]  STD_MASK  = ID_W'((64'd1 << STD_ID_W) - 64'd1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(NUM_RULES);

  // rule table, one register set per rule
  logic [ID_W-1:0]    rId      [NUM_RULES];
  logic               rIde     [NUM_RULES];
  logic               rRtr     [NUM_RULES];
  logic [ID_W-1:0]    rIdMask  [NUM_RULES];
  logic               rIdeMask [NUM_RULES];
  logic               rRtrMask [NUM_RULES];
  logic [DLC_W-1:0]   rDlc     [NUM_RULES];
  logic [LABEL_W-1:0] rLabel   [NUM_RULES];
  logic               rBufEn   [NUM_RULES];
  logic [BUF_W-1:0]   rBufIdx  [NUM_RULES];
  logic [FIFO_W-1:0]  rFifoSel [NUM_RULES];

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
    logic wrHere;
    assign wrHere = ctl.tableWrOk && ruleWrEn && (ruleWrIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rId[g]      <= '0;
        rIde[g]     <= 1'b0;
        rRtr[g]     <= 1'b0;
        rIdMask[g]  <= '0;
        rIdeMask[g] <= 1'b0;
        rRtrMask[g] <= 1'b0;
        rDlc[g]     <= '0;
        rLabel[g]   <= '0;
        rBufEn[g]   <= 1'b0;
        rBufIdx[g]  <= '0;
        rFifoSel[g] <= '0;
      end else if (wrHere) begin
        rId[g]      <= ruleWrId;
        rIde[g]     <= ruleWrIde;
        rRtr[g]     <= ruleWrRtr;
        rIdMask[g]  <= ruleWrIdMask;
        rIdeMask[g] <= ruleWrIdeMask;
        rRtrMask[g] <= ruleWrRtrMask;
        rDlc[g]     <= ruleWrDlc;
        rLabel[g]   <= ruleWrLabel;
        rBufEn[g]   <= ruleWrBufEn;
        rBufIdx[g]  <= ruleWrBufIdx;
        rFifoSel[g] <= ruleWrFifoSel;
      end
    end
  end

  // active rule count, clamped on write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ruleCount <= '0;
    end else if (ctl.tableWrOk && cntWrEn) begin
      ruleCount <= (cntWrData > CNT_LIMIT) ? CNT_LIMIT : cntWrData;
    end
  end

  // captured frame header and walk index
  logic [ID_W-1:0]  fId;
  logic             fIde;
  logic             fRtr;
  logic [DLC_W-1:0] fDlc;
  logic [IDX_W-1:0] scanIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fId     <= '0;
      fIde    <= 1'b0;
      fRtr    <= 1'b0;
      fDlc    <= '0;
      scanIdx <= '0;
    end else if (ctl.loadFrame) begin
      fId     <= frmId;
      fIde    <= frmIde;
      fRtr    <= frmRtr;
      fDlc    <= frmDlc;
      scanIdx <= '0;
    end else if (ctl.stepIdx) begin
      scanIdx <= scanIdx + IDX_W'(1);
    end
  end

  // compare the frame against the rule under the walk index
  logic [ID_W-1:0] effMask;
  logic            idBitsOk;
  logic            ideOk;
  logic            rtrOk;
  logic            acceptNow;

  always_comb begin
    effMask  = fIde ? rIdMask[scanIdx] : (rIdMask[scanIdx] & STD_MASK);
    idBitsOk = (((fId ^ rId[scanIdx]) & effMask) == '0);
    ideOk    = !rIdeMask[scanIdx] || (fIde == rIde[scanIdx]);
    rtrOk    = !rRtrMask[scanIdx] || (fRtr == rRtr[scanIdx]);

    sts.inRange  = (CNT_W'(scanIdx) < ruleCount);
    sts.idHit    = sts.inRange && idBitsOk && ideOk && rtrOk;
    sts.dlcOk    = (rDlc[scanIdx] == '0) || (fDlc >= rDlc[scanIdx]);
    sts.lastRule = ((CNT_W'(scanIdx) + CNT_W'(1)) == ruleCount);

    acceptNow = sts.idHit && sts.dlcOk;
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resMatch   <= 1'b0;
      resRuleIdx <= '0;
      resLabel   <= '0;
      resDlc     <= '0;
      resBufEn   <= 1'b0;
      resBufIdx  <= '0;
      resFifoSel <= '0;
    end else if (ctl.capture) begin
      resMatch <= acceptNow;
      if (acceptNow) begin
        resRuleIdx <= scanIdx;
        resLabel   <= rLabel[scanIdx];
        resDlc     <= rDlc[scanIdx];
        resBufEn   <= rBufEn[scanIdx];
        resBufIdx  <= rBufIdx[scanIdx];
        resFifoSel <= rFifoSel[scanIdx];
      end else begin
        resRuleIdx <= '0;
        resLabel   <= '0;
        resDlc     <= '0;
        resBufEn   <= 1'b0;
        resBufIdx  <= '0;
        resFifoSel <= '0;
      end
    end
  end

endmodule

// File: rtl/can_rx_rule_filter.sv
module can_rx_rule_filter
  import rxf_pkg::*;
#(
  parameter int NUM_RULES = 16,
  parameter int ID_W      = 29,
  parameter int STD_ID_W  = 11,
  parameter int DLC_W     = 4,
  parameter int LABEL_W   = 12,
  parameter int BUF_W     = 4,
  parameter int FIFO_W    = 3,
  localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1,
  localparam int CNT_W    = $clog2(NUM_RULES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ruleWrEn,
  input  logic [IDX_W-1:0]   ruleWrIdx,
  input  logic [ID_W-1:0]    ruleWrId,
  input  logic               ruleWrIde,
  input  logic               ruleWrRtr,
  input  logic [ID_W-1:0]    ruleWrIdMask,
  input  logic               ruleWrIdeMask,
  input  logic               ruleWrRtrMask,
  input  logic [DLC_W-1:0]   ruleWrDlc,
  input  logic [LABEL_W-1:0] ruleWrLabel,
  input  logic               ruleWrBufEn,
  input  logic [BUF_W-1:0]   ruleWrBufIdx,
  input  logic [FIFO_W-1:0]  ruleWrFifoSel,
  input  logic               cntWrEn,
  input  logic [CNT_W-1:0]   cntWrData,
  input  logic               frmValid,
  output logic               frmReady,
  input  logic [ID_W-1:0]    frmId,
  input  logic               frmIde,
  input  logic               frmRtr,
  input  logic [DLC_W-1:0]   frmDlc,
  output logic               resValid,
  output logic               resMatch,
  output logic [IDX_W-1:0]   resRuleIdx,
  output logic [LABEL_W-1:0] resLabel,
  output logic [DLC_W-1:0]   resDlc,
  output logic               resBufEn,
  output logic [BUF_W-1:0]   resBufIdx,
  output logic [FIFO_W-1:0]  resFifoSel
);

  rxf_ctl_t         ctl;
  rxf_sts_t         sts;
  logic [CNT_W-1:0] ruleCount;

  rxf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frmValid (frmValid),
    .sts      (sts),
    .ctl      (ctl),
    .frmReady (frmReady),
    .resValid (resValid)
  );

  rxf_dp #(
    .NUM_RULES (NUM_RULES),
    .ID_W      (ID_W),
    .STD_ID_W  (STD_ID_W),
    .DLC_W     (DLC_W),
    .LABEL_W   (LABEL_W),
    .BUF_W     (BUF_W),
    .FIFO_W    (FIFO_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .sts           (sts),
    .ruleWrEn      (ruleWrEn),
    .ruleWrIdx     (ruleWrIdx),
    .ruleWrId      (ruleWrId),
    .ruleWrIde     (ruleWrIde),
    .ruleWrRtr     (ruleWrRtr),
    .ruleWrIdMask  (ruleWrIdMask),
    .ruleWrIdeMask (ruleWrIdeMask),
    .ruleWrRtrMask (ruleWrRtrMask),
    .ruleWrDlc     (ruleWrDlc),
    .ruleWrLabel   (ruleWrLabel),
    .ruleWrBufEn   (ruleWrBufEn),
    .ruleWrBufIdx  (ruleWrBufIdx),
    .ruleWrFifoSel (ruleWrFifoSel),
    .cntWrEn       (cntWrEn),
    .cntWrData     (cntWrData),
    .frmId         (frmId),
    .frmIde        (frmIde),
    .frmRtr        (frmRtr),
    .frmDlc        (frmDlc),
    .ruleCount     (ruleCount),
    .resMatch      (resMatch),
    .resRuleIdx    (resRuleIdx),
    .resLabel      (resLabel),
    .resDlc        (resDlc),
    .resBufEn      (resBufEn),
    .resBufIdx     (resBufIdx),
    .resFifoSel    (resFifoSel)
  );

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int NUM_RULES = 16,
  parameter int DLC_W     = 4,
  parameter int LABEL_W   = 12,
  parameter int BUF_W     = 4,
  parameter int FIFO_W    = 3,
  localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1,
  localparam int CNT_W    = $clog2(NUM_RULES + 1),
  localparam int BSY_W    = $clog2(NUM_RULES + 2) + 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               frmValid,
  input logic               frmReady,
  input logic               resValid,
  input logic               resMatch,
  input logic [IDX_W-1:0]   resRuleIdx,
  input logic [LABEL_W-1:0] resLabel,
  input logic [DLC_W-1:0]   resDlc,
  input logic               resBufEn,
  input logic [BUF_W-1:0]   resBufIdx,
  input logic [FIFO_W-1:0]  resFifoSel,
  input logic [CNT_W-1:0]   ruleCount
);

  // counts busy cycles to bound the walk length
  logic [BSY_W-1:0] busyCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (frmReady) busyCnt <= '0;
    else busyCnt <= busyCnt + BSY_W'(1);
  end

  p_busy_after_take_r1: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && frmReady) |=> !frmReady);

  p_ready_with_result_r1: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> frmReady);

  p_zero_count_rejects_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && ruleCount == '0) |-> !resMatch);

  p_hit_in_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resMatch) |-> (CNT_W'(resRuleIdx) < ruleCount));

  p_walk_bounded_r7: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= BSY_W'(NUM_RULES));

  p_discard_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resMatch) |-> (resRuleIdx == '0 && resLabel == '0 && resDlc == '0
                                 && !resBufEn && resBufIdx == '0 && resFifoSel == '0));

  p_count_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    !frmReady |=> $stable(ruleCount));

  p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

endmodule

bind can_rx_rule_filter rxf_checker #(
  .NUM_RULES (NUM_RULES),
  .DLC_W     (DLC_W),
  .LABEL_W   (LABEL_W),
  .BUF_W     (BUF_W),
  .FIFO_W    (FIFO_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frmValid   (frmValid),
  .frmReady   (frmReady),
  .resValid   (resValid),
  .resMatch   (resMatch),
  .resRuleIdx (resRuleIdx),
  .resLabel   (resLabel),
  .resDlc     (resDlc),
  .resBufEn   (resBufEn),
  .resBufIdx  (resBufIdx),
  .resFifoSel (resFifoSel),
  .ruleCount  (ruleCount)
);

// File: tb/sim_can_rx_rule_filter.sv
module sim_can_rx_rule_filter;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ruleWrEn = 1'b0;
  logic [3:0]  ruleWrIdx = '0;
  logic [28:0] ruleWrId = '0;
  logic        ruleWrIde = 1'b0;
  logic        ruleWrRtr = 1'b0;
  logic [28:0] ruleWrIdMask = '0;
  logic        ruleWrIdeMask = 1'b0;
  logic        ruleWrRtrMask = 1'b0;
  logic [3:0]  ruleWrDlc = '0;
  logic [11:0] ruleWrLabel = '0;
  logic        ruleWrBufEn = 1'b0;
  logic [3:0]  ruleWrBufIdx = '0;
  logic [2:0]  ruleWrFifoSel = '0;
  logic        cntWrEn = 1'b0;
  logic [4:0]  cntWrData = '0;
  logic        frmValid = 1'b0;
  logic        frmReady;
  logic [28:0] frmId = '0;
  logic        frmIde = 1'b0;
  logic        frmRtr = 1'b0;
  logic [3:0]  frmDlc = '0;
  logic        resValid;
  logic        resMatch;
  logic [3:0]  resRuleIdx;
  logic [11:0] resLabel;
  logic [3:0]  resDlc;
  logic        resBufEn;
  logic [3:0]  resBufIdx;
  logic [2:0]  resFifoSel;

  always #(CLK_PERIOD / 2) clk = ~clk;

  can_rx_rule_filter u0 (.*);

  int nChecks = 0;
  int nFails  = 0;
  bit summaryDone = 1'b0;

  // bench copy of the table as written
  logic [28:0] mId [NR];
  logic        mIde [NR];
  logic        mRtr [NR];
  logic [28:0] mIdM [NR];
  logic        mIdeM [NR];
  logic        mRtrM [NR];
  logic [3:0]  mDlc [NR];
  logic [11:0] mLabel [NR];
  logic        mBufEn [NR];
  logic [3:0]  mBufIdx [NR];
  logic [2:0]  mFifo [NR];
  int          mCount = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeRule(input int i, input logic [28:0] id, input logic ide, input logic rtr,
                           input logic [28:0] idm, input logic idem, input logic rtrm,
                           input logic [3:0] dlc, input logic [11:0] lab, input logic bEn,
                           input logic [3:0] bIdx, input logic [2:0] fifo);
    @(negedge clk);
    ruleWrEn = 1'b1; ruleWrIdx = 4'(i); ruleWrId = id; ruleWrIde = ide; ruleWrRtr = rtr;
    ruleWrIdMask = idm; ruleWrIdeMask = idem; ruleWrRtrMask = rtrm; ruleWrDlc = dlc;
    ruleWrLabel = lab; ruleWrBufEn = bEn; ruleWrBufIdx = bIdx; ruleWrFifoSel = fifo;
    @(negedge clk);
    ruleWrEn = 1'b0;
    mId[i] = id; mIde[i] = ide; mRtr[i] = rtr; mIdM[i] = idm; mIdeM[i] = idem;
    mRtrM[i] = rtrm; mDlc[i] = dlc; mLabel[i] = lab; mBufEn[i] = bEn;
    mBufIdx[i] = bIdx; mFifo[i] = fifo;
  endtask

  task automatic writeCount(input int n);
    @(negedge clk);
    cntWrEn = 1'b1; cntWrData = 5'(n);
    @(negedge clk);
    cntWrEn = 1'b0;
    mCount = (n > NR) ? NR : n;
  endtask

  function automatic logic [28:0] uniqId(input int i);
    return 29'h1000000 + 29'(i * 37 + 5);
  endfunction

  task automatic loadUnique();
    for (int i = 0; i < NR; i++)
      writeRule(i, uniqId(i), 1'b1, 1'b0, 29'h1FFFFFFF, 1'b1, 1'b1, 4'd0,
                12'(i * 3 + 1), i[0], 4'(15 - i), 3'(i % 5 + 1));
  endtask

  // expected outcome from the requirements
  task automatic model(input logic [28:0] id, input logic ide, input logic rtr, input logic [3:0] dlc,
                       output bit eMatch, output int eIdx, output int eLat);
    logic [28:0] msk;
    eMatch = 1'b0; eIdx = 0; eLat = (mCount == 0) ? 1 : mCount;
    for (int i = 0; i < mCount; i++) begin
      msk = ide ? mIdM[i] : (mIdM[i] & 29'h7FF);
      if (((id ^ mId[i]) & msk) == 29'd0 && (!mIdeM[i] || ide == mIde[i])
          && (!mRtrM[i] || rtr == mRtr[i])) begin
        eLat = i + 1;
        if (mDlc[i] == 4'd0 || dlc >= mDlc[i]) begin
          eMatch = 1'b1; eIdx = i;
        end
        return;
      end
    end
  endtask

  task automatic runFrame(input logic [28:0] id, input logic ide, input logic rtr,
                          input logic [3:0] dlc, input string req, input bit inject);
    bit eMatch; int eIdx; int eLat; int lat;
    model(id, ide, rtr, dlc, eMatch, eIdx, eLat);
    @(negedge clk);
    check(frmReady == 1'b1, "R1", "ready before offer", frmReady, 1);
    frmValid = 1'b1; frmId = id; frmIde = ide; frmRtr = rtr; frmDlc = dlc;
    @(posedge clk);
    @(negedge clk);
    frmValid = 1'b0;
    check(frmReady == 1'b0, "R1", "ready during walk", frmReady, 0);
    if (inject) begin
      // R9: try to make rule 0 match everything and shrink the count mid-walk
      ruleWrEn = 1'b1; ruleWrIdx = 4'd0; ruleWrIdMask = '0; ruleWrIdeMask = 1'b0;
      ruleWrRtrMask = 1'b0; ruleWrDlc = 4'd0;
      cntWrEn = 1'b1; cntWrData = 5'd1;
    end
    lat = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (lat == 1) begin ruleWrEn = 1'b0; cntWrEn = 1'b0; end
    end while (!resValid && lat < 40);
    check(lat == eLat, req, "strobe cycle (R7)", lat, eLat);
    check(resMatch == eMatch, req, "match", resMatch, eMatch);
    if (eMatch) begin
      check(resRuleIdx == 4'(eIdx), req, "rule index (R2)", resRuleIdx, eIdx);
      check(resLabel == mLabel[eIdx] && resDlc == mDlc[eIdx] && resBufEn == mBufEn[eIdx]
            && resBufIdx == mBufIdx[eIdx] && resFifoSel == mFifo[eIdx],
            "R8", "payload", {resLabel, resDlc, resBufEn, resBufIdx, resFifoSel},
            {mLabel[eIdx], mDlc[eIdx], mBufEn[eIdx], mBufIdx[eIdx], mFifo[eIdx]});
    end else begin
      check(resRuleIdx == 0 && resLabel == 0 && resDlc == 0 && !resBufEn
            && resBufIdx == 0 && resFifoSel == 0, "R8", "discard payload zero",
            {resLabel, resDlc, resBufEn, resBufIdx, resFifoSel}, 0);
    end
    check(frmReady == 1'b1, "R1", "ready in result cycle", frmReady, 1);
    @(negedge clk);
    check(resValid == 1'b0, "R10", "strobe one cycle", resValid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!summaryDone) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summaryDone = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin
      mId[i] = '0; mIde[i] = 0; mRtr[i] = 0; mIdM[i] = '0; mIdeM[i] = 0; mRtrM[i] = 0;
      mDlc[i] = '0; mLabel[i] = '0; mBufEn[i] = 0; mBufIdx[i] = '0; mFifo[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(frmReady == 1'b1, "R1", "reset ready", frmReady, 1);
    check(resValid == 1'b0, "R10", "reset strobe", resValid, 0);

    // R5: reset table is all-wildcard but count 0 accepts nothing
    runFrame(29'h0, 1'b0, 1'b0, 4'd0, "R5", 1'b0);
    runFrame(29'h1234567, 1'b1, 1'b1, 4'd8, "R5", 1'b0);

    // R2 R7 R8: each rule hit in turn, plus a full miss
    loadUnique();
    writeCount(16);
    for (int k = 0; k < NR; k++) runFrame(uniqId(k), 1'b1, 1'b0, 4'd3, "R2", 1'b0);
    runFrame(29'h0ABCDEF, 1'b1, 1'b0, 4'd3, "R7", 1'b0);
    runFrame(uniqId(4), 1'b1, 1'b1, 4'd3, "R3", 1'b0);
    runFrame(uniqId(4), 1'b0, 1'b0, 4'd3, "R3", 1'b0);

    // R5: count sweep, last active rule hits, first inactive rule misses
    for (int n = 1; n <= NR; n++) begin
      writeCount(n);
      runFrame(uniqId(n - 1), 1'b1, 1'b0, 4'd0, "R5", 1'b0);
      if (n < NR) runFrame(uniqId(n), 1'b1, 1'b0, 4'd0, "R5", 1'b0);
    end
    writeCount(25);
    runFrame(uniqId(15), 1'b1, 1'b0, 4'd0, "R5", 1'b0);

    // R2: two rules share an identifier, lower one wins
    writeRule(9, uniqId(3), 1'b1, 1'b0, 29'h1FFFFFFF, 1'b1, 1'b1, 4'd0, 12'hA09, 1'b1, 4'd9, 3'd4);
    runFrame(uniqId(3), 1'b1, 1'b0, 4'd0, "R2", 1'b0);
    runFrame(uniqId(9), 1'b1, 1'b0, 4'd0, "R2", 1'b0);

    // R3: per-bit identifier mask sweep on rule 0
    for (int b = 0; b < 29; b++) begin
      writeRule(0, 29'h0AAAAAAA, 1'b1, 1'b0, ~(29'd1 << b), 1'b1, 1'b1, 4'd0, 12'(b), 1'b1, 4'd2, 3'd1);
      runFrame(29'h0AAAAAAA ^ (29'd1 << b), 1'b1, 1'b0, 4'd0, "R3", 1'b0);
      runFrame(29'h0AAAAAAA ^ (29'd3 << (b % 28)), 1'b1, 1'b0, 4'd0, "R3", 1'b0);
    end
    // R3: IDE and RTR masks
    writeRule(0, 29'h0AAAAAAA, 1'b1, 1'b1, 29'h1FFFFFFF, 1'b0, 1'b0, 4'd0, 12'h777, 1'b0, 4'd1, 3'd2);
    for (int c = 0; c < 4; c++) runFrame(29'h0AAAAAAA, c[0], c[1], 4'd0, "R3", 1'b0);
    writeRule(0, 29'h0AAAAAAA, 1'b1, 1'b1, 29'h1FFFFFFF, 1'b1, 1'b1, 4'd0, 12'h778, 1'b0, 4'd1, 3'd2);
    for (int c = 0; c < 4; c++) runFrame(29'h0AAAAAAA, c[0], c[1], 4'd0, "R3", 1'b0);

    // R4: standard frames compare only the low 11 bits
    writeRule(0, 29'h1FFFF923, 1'b0, 1'b0, 29'h1FFFFFFF, 1'b1, 1'b1, 4'd0, 12'h123, 1'b1, 4'd5, 3'd1);
    runFrame(29'h0000123, 1'b0, 1'b0, 4'd0, "R4", 1'b0);
    runFrame(29'h1555123, 1'b0, 1'b0, 4'd0, "R4", 1'b0);
    runFrame(29'h0000124, 1'b0, 1'b0, 4'd0, "R4", 1'b0);
    writeRule(0, 29'h1FFFF923, 1'b1, 1'b0, 29'h1FFFFFFF, 1'b1, 1'b1, 4'd0, 12'h124, 1'b1, 4'd5, 3'd1);
    runFrame(29'h0000123, 1'b1, 1'b0, 4'd0, "R4", 1'b0);
    runFrame(29'h1FFFF923, 1'b1, 1'b0, 4'd0, "R4", 1'b0);

    // R6: DLC threshold sweep; rule 1 also matches but must never be reached
    writeRule(1, 29'h0C0FFEE, 1'b1, 1'b0, 29'h1FFFFFFF, 1'b1, 1'b1, 4'd0, 12'hBBB, 1'b1, 4'd7, 3'd7);
    for (int d = 0; d < 16; d++) begin
      writeRule(0, 29'h0C0FFEE, 1'b1, 1'b0, 29'h1FFFFFFF, 1'b1, 1'b1, 4'(d), 12'(d + 100), 1'b0, 4'd3, 3'd2);
      for (int f = 0; f < 16; f++) runFrame(29'h0C0FFEE, 1'b1, 1'b0, 4'(f), "R6", 1'b0);
    end

    // R9: writes offered mid-walk are dropped, then the next frame sees the old table
    loadUnique();
    writeCount(16);
    runFrame(29'h0, 1'b0, 1'b0, 4'd0, "R9", 1'b1);
    runFrame(29'h0, 1'b0, 1'b0, 4'd0, "R9", 1'b0);
    runFrame(uniqId(15), 1'b1, 1'b0, 4'd0, "R9", 1'b0);

    summaryDone = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule